// File: doc/BRIEF.md
# Secure Sector Access and Erase Gating

This block decides, one command at a time, whether a flash device may carry out a decoded command while a one-time-programmable secure sector can be mapped over the normal array. The command decoder presents one command per cycle. The block judges that command against three things: the current secure-mode state, the suspend-state flag from the program/erase engine, and the secure-sector protection bit. One cycle later it answers with a single accept or reject strobe in the bit position of that command.

An accepted secure-entry command maps the secure overlay in. An accepted secure-exit command removes it. While the overlay is active, array programming and resume are held off, so a suspended program or erase cannot restart until the overlay is removed. An accepted chip erase produces a registered per-sector erase-enable mask for the erase engine. The mask always leaves out the boot sector chosen by the boot-block configuration. The secure sector has no bit in the mask and therefore can never be erased.

The protection bit is non-volatile storage held outside this block. Reset does not affect it. Reset only clears secure mode and the strobes.

Top module: `secure_gate`

## Requirements
- R1: After reset, secure_mode is 0, and erase_go, erase_mask, acc_vec and rej_vec are all zero.
- R2: Secure entry (cmd_op 0) is always accepted, whether or not an operation is suspended. secure_mode reads 1 from the cycle after acceptance.
- R3: Secure exit (cmd_op 1) is accepted only while secure_mode is 1, and it clears secure_mode. When secure_mode is 0, secure exit is rejected.
- R4: Chip erase (cmd_op 2) is accepted in either mode. On acceptance, erase_go pulses for one cycle and erase_mask carries the enable pattern for that cycle. erase_mask is zero whenever erase_go is 0.
- R5: The chip-erase mask has NUM_SECTORS bits, one per array sector. All bits are set except one: bit 0 is clear when boot_top is 1, and bit NUM_SECTORS-1 (45 by default) is clear when boot_top is 0. The secure sector has no mask bit.
- R6: Resume (cmd_op 5) is rejected while secure_mode is 1, including while suspended. It is also rejected when suspended is 0. It is accepted only when suspended is 1 and secure_mode is 0.
- R7: A program aimed at the secure area (cmd_op 3 with prog_secure 1) is rejected whenever prot_bit is 1, and also whenever secure_mode is 0. It is accepted when secure_mode is 1 and prot_bit is 0.
- R8: A program aimed at the array (cmd_op 3 with prog_secure 0) is rejected while secure_mode is 1 and accepted while secure_mode is 0.
- R9: Suspend (cmd_op 4) is accepted only when secure_mode is 0 and suspended is 0. Otherwise it is rejected.
- R10: For each command with cmd_valid 1 and cmd_op 0 to 5, exactly one of acc_vec[cmd_op] and rej_vec[cmd_op] is 1 in the next cycle, and every other strobe bit is 0. cmd_op 6 and 7, and any cycle with cmd_valid 0, produce no strobe and change no state.
- R11: A rejected command leaves secure_mode unchanged and produces no erase_go.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code: 0 entry, 1 exit, 2 chip erase, 3 program, 4 suspend, 5 resume |
| prog_secure | input | 1 | Program target lies in the secure area |
| boot_top | input | 1 | 1 = top-boot configuration, 0 = bottom-boot |
| suspended | input | 1 | A program or erase operation is currently suspended |
| prot_bit | input | 1 | Non-volatile secure-sector protection bit |
| secure_mode | output | 1 | Secure overlay is mapped in |
| erase_go | output | 1 | One-cycle strobe: chip erase accepted |
| erase_mask | output | NUM_SECTORS | Per-sector erase enables, valid with erase_go |
| acc_vec | output | 6 | Accept strobe, bit index = command code |
| rej_vec | output | 6 | Reject strobe, bit index = command code |

## Verification
Two functions can fall in the same cycle. A suspend-state flag that is raised while the secure overlay is active asks for two opposite outcomes: entry is permitted, but resume must be refused. The bench provokes this directly by entering secure mode with suspended held high and then issuing resume. It also reaches the same combinations through seeded random streams that draw the mode flags independently of the command. Each strobe vector, secure_mode and the erase mask are judged against a bench-side model of the acceptance rules, one cycle after each command.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam int NUM_OPS = 6;

  typedef enum logic [2:0] {
    OP_ENTRY   = 3'd0,
    OP_EXIT    = 3'd1,
    OP_CHIP_ER = 3'd2,
    OP_PROGRAM = 3'd3,
    OP_SUSPEND = 3'd4,
    OP_RESUME  = 3'd5
  } ssg_op_e;
endpackage

// File: rtl/ssg_judge.sv
module ssg_judge
  import ssg_pkg::*;
(
  input  logic               op_valid,
  input  logic [2:0]         op,
  input  logic               sec,
  input  logic               prog_secure,
  input  logic               suspended,
  input  logic               prot_bit,
  output logic [NUM_OPS-1:0] acc_now,
  output logic [NUM_OPS-1:0] rej_now
);
  logic known;
  logic ok;
  logic [NUM_OPS-1:0] sel;

  always_comb begin
    known = 1'b1;
    ok    = 1'b0;
    sel   = '0;
    case (op)
      OP_ENTRY:   begin sel[0] = 1'b1; ok = 1'b1; end
      OP_EXIT:    begin sel[1] = 1'b1; ok = sec; end
      OP_CHIP_ER: begin sel[2] = 1'b1; ok = 1'b1; end
      OP_PROGRAM: begin
        sel[3] = 1'b1;
        ok = prog_secure ? (sec && !prot_bit) : !sec;
      end
      OP_SUSPEND: begin sel[4] = 1'b1; ok = !sec && !suspended; end
      OP_RESUME:  begin sel[5] = 1'b1; ok = !sec && suspended; end
      default:    known = 1'b0;
    endcase
  end

  assign acc_now = (op_valid && known &&  ok) ? sel : '0;
  assign rej_now = (op_valid && known && !ok) ? sel : '0;
endmodule

// File: rtl/ssg_mode_reg.sv
module ssg_mode_reg
  import ssg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OPS-1:0] acc_now,
  output logic               sec
);
  always_ff @(posedge clk) begin
    if (rst)
      sec <= 1'b0;
    else if (acc_now[OP_ENTRY])
      sec <= 1'b1;
    else if (acc_now[OP_EXIT])
      sec <= 1'b0;
  end
endmodule

// File: rtl/ssg_mask_gen.sv
module ssg_mask_gen #(
  parameter int NUM_SECTORS     = 46,
  parameter int TOP_BOOT_IDX    = 0,
  parameter int BOTTOM_BOOT_IDX = NUM_SECTORS - 1
) (
  input  logic                   boot_top,
  output logic [NUM_SECTORS-1:0] mask
);
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sec
    if (i == TOP_BOOT_IDX && i == BOTTOM_BOOT_IDX) begin : g_both
      assign mask[i] = 1'b0;
    end else if (i == TOP_BOOT_IDX) begin : g_top
      assign mask[i] = !boot_top;
    end else if (i == BOTTOM_BOOT_IDX) begin : g_bot
      assign mask[i] = boot_top;
    end else begin : g_plain
      assign mask[i] = 1'b1;
    end
  end
endmodule

// File: rtl/secure_gate.sv
module secure_gate
  import ssg_pkg::*;
#(
  parameter int NUM_SECTORS     = 46,
  parameter int TOP_BOOT_IDX    = 0,
  parameter int BOTTOM_BOOT_IDX = NUM_SECTORS - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic                   prog_secure,
  input  logic                   boot_top,
  input  logic                   suspended,
  input  logic                   prot_bit,
  output logic                   secure_mode,
  output logic                   erase_go,
  output logic [NUM_SECTORS-1:0] erase_mask,
  output logic [NUM_OPS-1:0]     acc_vec,
  output logic [NUM_OPS-1:0]     rej_vec
);
  logic [NUM_OPS-1:0]     acc_now;
  logic [NUM_OPS-1:0]     rej_now;
  logic [NUM_SECTORS-1:0] mask_now;

  ssg_judge u_judge (
    .op_valid    (cmd_valid),
    .op          (cmd_op),
    .sec         (secure_mode),
    .prog_secure (prog_secure),
    .suspended   (suspended),
    .prot_bit    (prot_bit),
    .acc_now     (acc_now),
    .rej_now     (rej_now)
  );

  ssg_mode_reg u_mode (
    .clk     (clk),
    .rst     (rst),
    .acc_now (acc_now),
    .sec     (secure_mode)
  );

  ssg_mask_gen #(
    .NUM_SECTORS     (NUM_SECTORS),
    .TOP_BOOT_IDX    (TOP_BOOT_IDX),
    .BOTTOM_BOOT_IDX (BOTTOM_BOOT_IDX)
  ) u_mask (
    .boot_top (boot_top),
    .mask     (mask_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_vec    <= '0;
      rej_vec    <= '0;
      erase_go   <= 1'b0;
      erase_mask <= '0;
    end else begin
      acc_vec    <= acc_now;
      rej_vec    <= rej_now;
      erase_go   <= acc_now[OP_CHIP_ER];
      erase_mask <= acc_now[OP_CHIP_ER] ? mask_now : '0;
    end
  end
endmodule

// File: rtl/secure_gate_chk.sv
module secure_gate_chk
  import ssg_pkg::*;
#(
  parameter int NUM_SECTORS     = 46,
  parameter int TOP_BOOT_IDX    = 0,
  parameter int BOTTOM_BOOT_IDX = NUM_SECTORS - 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cmd_valid,
  input logic [2:0]             cmd_op,
  input logic                   prog_secure,
  input logic                   boot_top,
  input logic                   suspended,
  input logic                   prot_bit,
  input logic                   secure_mode,
  input logic                   erase_go,
  input logic [NUM_SECTORS-1:0] erase_mask,
  input logic [NUM_OPS-1:0]     acc_vec,
  input logic [NUM_OPS-1:0]     rej_vec
);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(acc_vec | rej_vec) && ((acc_vec & rej_vec) == '0));

  p_entry_ok_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd0) |=> (acc_vec[0] && secure_mode));

  p_exit_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1 && !secure_mode) |=> rej_vec[1]);

  p_erase_top_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && boot_top) |=>
      (erase_go && !erase_mask[TOP_BOOT_IDX] && $countones(erase_mask) == NUM_SECTORS - 1));

  p_erase_bot_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && !boot_top) |=>
      (erase_go && !erase_mask[BOTTOM_BOOT_IDX] && $countones(erase_mask) == NUM_SECTORS - 1));

  p_mask_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !erase_go |-> (erase_mask == '0));

  p_resume_secure_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd5 && (secure_mode || !suspended)) |=> rej_vec[5]);

  p_prot_prog_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd3 && prog_secure && prot_bit) |=> rej_vec[3]);

  p_array_prog_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd3 && !prog_secure && secure_mode) |=> rej_vec[3]);

  p_reject_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (|rej_vec) |-> (!erase_go && secure_mode == $past(secure_mode)));
endmodule

bind secure_gate secure_gate_chk #(
  .NUM_SECTORS     (NUM_SECTORS),
  .TOP_BOOT_IDX    (TOP_BOOT_IDX),
  .BOTTOM_BOOT_IDX (BOTTOM_BOOT_IDX)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .prog_secure (prog_secure),
  .boot_top    (boot_top),
  .suspended   (suspended),
  .prot_bit    (prot_bit),
  .secure_mode (secure_mode),
  .erase_go    (erase_go),
  .erase_mask  (erase_mask),
  .acc_vec     (acc_vec),
  .rej_vec     (rej_vec)
);

// File: tb/secure_gate_tb.sv
module secure_gate_tb;
  localparam int NS = 46;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic prog_secure = 1'b0;
  logic boot_top = 1'b0;
  logic suspended = 1'b0;
  logic prot_bit = 1'b0;
  logic secure_mode;
  logic erase_go;
  logic [NS-1:0] erase_mask;
  logic [5:0] acc_vec;
  logic [5:0] rej_vec;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit m_sec = 1'b0;

  always #5 clk = ~clk;

  secure_gate u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .prog_secure(prog_secure), .boot_top(boot_top), .suspended(suspended),
    .prot_bit(prot_bit), .secure_mode(secure_mode), .erase_go(erase_go),
    .erase_mask(erase_mask), .acc_vec(acc_vec), .rej_vec(rej_vec)
  );

  function automatic bit rule_ok(input logic [2:0] op, input bit sec, input bit ps,
                                 input bit susp, input bit prot);
    case (op)
      3'd0: return 1'b1;
      3'd1: return sec;
      3'd2: return 1'b1;
      3'd3: return ps ? (sec && !prot) : !sec;
      3'd4: return !sec && !susp;
      3'd5: return !sec && susp;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NS-1:0] exp_mask(input bit top);
    logic [NS-1:0] m = '1;
    if (top) m[0] = 1'b0; else m[NS-1] = 1'b0;
    return m;
  endfunction

  function automatic string tag_of(input logic [2:0] op, input bit v);
    if (!v) return "R10";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R7/R8";
      3'd4: return "R9";
      3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit v, input logic [2:0] op, input bit ps,
                       input bit top, input bit susp, input bit prot);
    bit known;
    bit ok;
    logic [5:0] e_acc;
    logic [5:0] e_rej;
    bit e_go;
    bit old_sec;
    string t;
    cmd_valid = v; cmd_op = op; prog_secure = ps;
    boot_top = top; suspended = susp; prot_bit = prot;
    known = v && (op < 3'd6);
    ok = rule_ok(op, m_sec, ps, susp, prot);
    e_acc = '0; e_rej = '0;
    if (known) begin
      if (ok) e_acc[op] = 1'b1; else e_rej[op] = 1'b1;
    end
    e_go = known && ok && op == 3'd2;
    old_sec = m_sec;
    if (known && ok && op == 3'd0) m_sec = 1'b1;
    if (known && ok && op == 3'd1) m_sec = 1'b0;
    t = tag_of(op, known);
    @(posedge clk);
    @(negedge clk);
    check({t, " R10 strobes"}, {52'd0, acc_vec, rej_vec}, {52'd0, e_acc, e_rej});
    check({t, " R11 mode"}, {63'd0, secure_mode}, {63'd0, m_sec});
    check({t, " R4 erase_go"}, {63'd0, erase_go}, {63'd0, e_go});
    check({t, " R5 mask"}, {18'd0, erase_mask}, e_go ? {18'd0, exp_mask(top)} : 64'd0);
    if (known && !ok) check("R11 reject keeps mode", {63'd0, secure_mode}, {63'd0, old_sec});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset mode", {63'd0, secure_mode}, 64'd0);
    check("R1 reset strobes", {52'd0, acc_vec, rej_vec}, 64'd0);
    check("R1 reset erase", {18'd0, erase_mask}, {63'd0, erase_go});
    // directed corner cases
    issue(1, 3'd1, 0, 0, 0, 0);            // R3 exit when idle rejected
    issue(1, 3'd5, 0, 0, 0, 0);            // R6 resume without suspend
    issue(1, 3'd4, 0, 0, 0, 0);            // R9 suspend accepted
    issue(1, 3'd0, 0, 0, 1, 0);            // R2 entry while suspended
    issue(1, 3'd5, 0, 0, 1, 0);            // R6 resume blocked in secure mode
    issue(1, 3'd2, 0, 1, 1, 0);            // R4/R5 chip erase top boot in secure mode
    issue(1, 3'd2, 0, 0, 1, 0);            // R5 bottom boot
    issue(1, 3'd3, 1, 0, 1, 1);            // R7 protected secure program
    issue(1, 3'd3, 1, 0, 1, 0);            // R7 unprotected secure program
    issue(1, 3'd3, 0, 0, 1, 0);            // R8 array program in secure mode
    issue(1, 3'd6, 0, 0, 1, 0);            // R10 unused code
    issue(1, 3'd1, 0, 0, 1, 0);            // R3 exit
    issue(1, 3'd5, 0, 0, 1, 0);            // R6 resume after exit
    issue(1, 3'd3, 1, 0, 0, 0);            // R7 secure program outside secure mode
    issue(0, 3'd0, 0, 0, 0, 0);            // R10 idle entry code
    begin
      int unsigned seed = 32'd1234;
      void'($urandom(seed));
    end
    for (int i = 0; i < 500; i++) begin
      int unsigned r = $urandom;
      issue((r[3:0] != 4'd0), r[6:4], r[7], r[8], r[9], r[10]);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule